// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block is the slave end of a parallel management bus in front of a multi-device switch. Behind it sit 32 internal register banks, each holding 32 sixteen-bit registers and selected by a 5-bit device number. The banks are modelled here as plain storage in a single inferred RAM.

A strap input picks the addressing scheme. When the strap is zero the bridge is flat: every bus phy address is a device number, and each bus access goes straight to that bank's register. When the strap is nonzero the bridge claims only that one phy address. There it offers a command register (register 0) and a data register (register 1). A master reaches any bank register by loading the data register if needed, writing a command, and polling until the busy flag drops.

Command word layout: bit 15 is busy/start, bits 14:10 the opcode, bits 9:5 the device, bits 4:0 the register. Opcode `5'b00110` reads (0x9800 base) and `5'b00101` writes (0x9400 base). A bus read returns data with `bus_rvalid` one cycle after the read strobe. If read and write strobes arrive together, the write is taken and the read is dropped.

Top module: `mgmt_indirect_bridge`

## Requirements
- R1: With strap 0, a write to phy p, register r stores the data in bank p, register r. A later read of phy p, register r returns it with `bus_rvalid` high in the cycle after the read strobe.
- R2: With a nonzero strap, an access whose phy differs from the strap gives no `bus_rvalid` and changes no state visible at the strap address or in any bank.
- R3: With a nonzero strap, register 1 at the strap address is a read/write data register. Register 0 reads back the command word {busy, opcode[14:10], device[9:5], register[4:0]}. Both read 0 after reset.
- R4: The command 0x9800 | dev<<5 | reg (opcode 5'b00110) loads the data register with bank dev, register reg by the time busy reads 0.
- R5: The command 0x9400 | dev<<5 | reg (opcode 5'b00101) stores the data register's current value into bank dev, register reg. The value is visible afterwards through both addressing schemes.
- R6: After a command with bit 15 set is accepted, the command register reads with bit 15 set on reads strobed in the next two cycles, and with bit 15 clear from the third cycle on. This is well within 16 polls.
- R7: A command write that arrives while busy is set is ignored: the command fields are unchanged and no bank is touched.
- R8: A command with bit 15 set and any other opcode in bits 14:10 runs the same busy timing and leaves every bank unchanged.
- R9: With a nonzero strap, reads of registers 2 to 31 at the strap address return 0, and writes to them have no effect.
- R10: A write to the command register with bit 15 clear starts nothing and leaves the command register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 5 | Bridge address; 0 selects flat mode |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_phy | input | 5 | Bus phy address |
| bus_reg | input | 5 | Bus register number |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after bus_rd |

## Verification
Most wrong internal state would surface in the polled command word within a few cycles. A sequencer stuck in a non-idle state shows bit 15 still set on the third poll. A command accepted while busy shows altered device or register fields on the very next poll. A corrupted bank entry or a misrouted RAM address only appears when that entry is read back, so every bank written by one addressing scheme is read back through the other. Decoding of foreign phy addresses is visible at once as a stray response strobe.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;
  localparam int unsigned OP_W = 5;
  localparam logic [OP_W-1:0] OP_RD = 5'b00110;
  localparam logic [OP_W-1:0] OP_WR = 5'b00101;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ISSUE = 2'd1,
    ENG_DONE  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/mgmt_bank_ram.sv
module mgmt_bank_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first single port, block RAM friendly
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/mgmt_cmd_engine.sv
module mgmt_cmd_engine
  import mgmt_bridge_pkg::*;
#(
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_wr,
  input  logic                   data_wr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      cmd_word,
  output logic [DATA_W-1:0]      data_word,
  output logic                   busy,
  output logic                   ram_en,
  output logic                   ram_we,
  output logic [DEV_W+REG_W-1:0] ram_addr,
  output logic [DATA_W-1:0]      ram_wdata,
  input  logic [DATA_W-1:0]      ram_q
);
  localparam int unsigned REG_LO = 0;
  localparam int unsigned DEV_LO = REG_W;
  localparam int unsigned OP_LO  = REG_W + DEV_W;
  localparam int unsigned START  = DATA_W - 1;

  eng_state_t        state_q;
  logic [OP_W-1:0]   op_q;
  logic [DEV_W-1:0]  dev_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              op_known;

  assign busy     = (state_q != ENG_IDLE);
  assign accept   = cmd_wr && !busy && wdata[START];
  assign op_known = (op_q == OP_RD) || (op_q == OP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      op_q    <= '0;
      dev_q   <= '0;
      reg_q   <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (accept) begin
          state_q <= ENG_ISSUE;
          op_q    <= wdata[OP_LO +: OP_W];
          dev_q   <= wdata[DEV_LO +: DEV_W];
          reg_q   <= wdata[REG_LO +: REG_W];
        end
        ENG_ISSUE: state_q <= ENG_DONE;
        default:   state_q <= ENG_IDLE;
      endcase
    end
  end

  // A completing read wins over a bus write to the data register
  always_ff @(posedge clk) begin
    if (rst)                                     data_q <= '0;
    else if (state_q == ENG_DONE && op_q == OP_RD) data_q <= ram_q;
    else if (data_wr)                            data_q <= wdata;
  end

  assign ram_en    = (state_q == ENG_ISSUE) && op_known;
  assign ram_we    = (state_q == ENG_ISSUE) && (op_q == OP_WR);
  assign ram_addr  = {dev_q, reg_q};
  assign ram_wdata = data_q;
  assign cmd_word  = {busy, op_q, dev_q, reg_q};
  assign data_word = data_q;

  AST_BUSY_HOLDS_TWO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R6
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy); // R6
  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable(cmd_word[DATA_W-2:0])); // R7
endmodule

// File: rtl/mgmt_indirect_bridge.sv
module mgmt_indirect_bridge #(
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  strap_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DEV_W-1:0]  bus_phy,
  input  logic [REG_W-1:0]  bus_reg,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int unsigned AW = DEV_W + REG_W;
  localparam logic [REG_W-1:0] CMD_IDX  = REG_W'(0);
  localparam logic [REG_W-1:0] DATA_IDX = REG_W'(1);

  logic              flat;
  logic              hit;
  logic              wr_go;
  logic              rd_go;
  logic              e_busy;
  logic              e_en;
  logic              e_we;
  logic [AW-1:0]     e_addr;
  logic [DATA_W-1:0] e_wdata;
  logic [DATA_W-1:0] e_cmd;
  logic [DATA_W-1:0] e_data;
  logic              m_en;
  logic              m_we;
  logic [AW-1:0]     m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W-1:0] m_q;
  logic              rvalid_q;
  logic              from_ram_q;
  logic [DATA_W-1:0] reg_resp_q;

  assign flat  = (strap_addr == '0);
  assign hit   = flat || (bus_phy == strap_addr);
  assign wr_go = bus_wr && hit;
  assign rd_go = bus_rd && !bus_wr && hit;

  mgmt_cmd_engine #(.DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (!flat && wr_go && bus_reg == CMD_IDX),
    .data_wr   (!flat && wr_go && bus_reg == DATA_IDX),
    .wdata     (bus_wdata),
    .cmd_word  (e_cmd),
    .data_word (e_data),
    .busy      (e_busy),
    .ram_en    (e_en),
    .ram_we    (e_we),
    .ram_addr  (e_addr),
    .ram_wdata (e_wdata),
    .ram_q     (m_q)
  );

  // Flat mode drives the bank storage from the bus, otherwise the engine does
  always_comb begin
    if (flat) begin
      m_en    = wr_go || rd_go;
      m_we    = wr_go;
      m_addr  = {bus_phy, bus_reg};
      m_wdata = bus_wdata;
    end else begin
      m_en    = e_en;
      m_we    = e_we;
      m_addr  = e_addr;
      m_wdata = e_wdata;
    end
  end

  mgmt_bank_ram #(.AW(AW), .DW(DATA_W)) u_banks (
    .clk   (clk),
    .en    (m_en),
    .we    (m_we),
    .addr  (m_addr),
    .wdata (m_wdata),
    .q     (m_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      reg_resp_q <= '0;
    end else begin
      rvalid_q   <= rd_go;
      from_ram_q <= flat;
      case (bus_reg)
        CMD_IDX:  reg_resp_q <= e_cmd;
        DATA_IDX: reg_resp_q <= e_data;
        default:  reg_resp_q <= '0;
      endcase
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = from_ram_q ? m_q : reg_resp_q;

  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && strap_addr != '0 && bus_phy != strap_addr) |=> !bus_rvalid); // R2
  AST_HIGH_REGS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && strap_addr != '0 && bus_phy == strap_addr && bus_reg > DATA_IDX)
      |=> (bus_rvalid && bus_rdata == '0)); // R9
  AST_FLAT_NO_ENGINE: assert property (@(posedge clk) disable iff (rst)
    (strap_addr == '0 && !e_busy) |=> !e_busy); // R1
endmodule

// File: tb/mgmt_indirect_bridge_tb_top.sv
module mgmt_indirect_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  strap_addr = 5'd3;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_phy = '0;
  logic [4:0]  bus_reg = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  int   stray = 0;
  bit   done = 1'b0;

  localparam logic [4:0] S = 5'd3;

  always #5 clk = ~clk;

  mgmt_indirect_bridge dut_i (
    .clk(clk), .rst(rst), .strap_addr(strap_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_phy(bus_phy), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // Monitor: compares every response strobe with the head of the queue
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        stray++;
        fails++;
        $display("FAIL R2: unexpected response got %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (bus_rdata !== e.val) begin
          fails++;
          $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic bw(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    bus_wr = 1'b1; bus_phy = phy; bus_reg = rg; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [4:0] phy, input logic [4:0] rg,
                    input logic [15:0] e, input string tag);
    exp_t x;
    x.val = e; x.tag = tag;
    exp_q.push_back(x);
    bus_rd = 1'b1; bus_phy = phy; bus_reg = rg;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic br_none(input logic [4:0] phy, input logic [4:0] rg);
    bus_rd = 1'b1; bus_phy = phy; bus_reg = rg;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] mk(input logic [4:0] op, input logic [4:0] dev,
                                     input logic [4:0] rg);
    return {1'b1, op, dev, rg};
  endfunction

  // Command followed by back-to-back polls: busy, busy, idle
  task automatic run_cmd(input logic [15:0] c, input string tag);
    bw(S, 5'd0, c);
    br(S, 5'd0, c, {tag, " R6 poll1"});
    br(S, 5'd0, c, {tag, " R6 poll2"});
    br(S, 5'd0, {1'b0, c[14:0]}, {tag, " R6 poll3"});
  endtask

  task automatic flush();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int stray_before;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3 reset state
    br(S, 5'd0, 16'h0000, "R3 cmd reset");
    br(S, 5'd1, 16'h0000, "R3 data reset");
    flush();

    // R1 flat mode
    strap_addr = 5'd0;
    @(negedge clk);
    bw(5'd0,  5'd0,  16'hA0A0);
    bw(5'd31, 5'd31, 16'hB1B1);
    bw(5'd7,  5'd13, 16'hC2C2);
    bw(5'd3,  5'd1,  16'hD3D3);
    br(5'd0,  5'd0,  16'hA0A0, "R1 bank0 reg0");
    br(5'd31, 5'd31, 16'hB1B1, "R1 bank31 reg31");
    br(5'd7,  5'd13, 16'hC2C2, "R1 bank7 reg13");
    br(5'd3,  5'd1,  16'hD3D3, "R1 bank3 reg1");
    flush();

    // Indirect mode
    strap_addr = S;
    @(negedge clk);
    bw(S, 5'd1, 16'h1234);
    br(S, 5'd1, 16'h1234, "R3 data readback");
    br(S, 5'd2, 16'h0000, "R9 reg2 zero");
    br(S, 5'd31, 16'h0000, "R9 reg31 zero");
    bw(S, 5'd5, 16'hFFFF);
    br(S, 5'd5, 16'h0000, "R9 write discarded");
    flush();

    // R2 foreign phy
    stray_before = stray;
    br_none(5'd4, 5'd1);
    bw(5'd4, 5'd1, 16'hBEEF);
    bw(5'd0, 5'd0, mk(5'b00101, 5'd7, 5'd13));
    flush();
    checks++;
    if (stray != stray_before) begin
      fails++;
      $display("FAIL R2: stray responses got %0d expected %0d", stray, stray_before);
    end
    br(S, 5'd1, 16'h1234, "R2 data untouched");
    br(S, 5'd0, 16'h0000, "R2 cmd untouched");
    flush();

    // R4 read commands
    run_cmd(mk(5'b00110, 5'd7, 5'd13), "R4 rd 7/13");
    br(S, 5'd1, 16'hC2C2, "R4 data 7/13");
    run_cmd(mk(5'b00110, 5'd31, 5'd31), "R4 rd 31/31");
    br(S, 5'd1, 16'hB1B1, "R4 data 31/31");
    flush();

    // R5 write command
    bw(S, 5'd1, 16'h5A5A);
    run_cmd(mk(5'b00101, 5'd9, 5'd2), "R5 wr 9/2");
    bw(S, 5'd1, 16'h0000);
    run_cmd(mk(5'b00110, 5'd9, 5'd2), "R5 rd 9/2");
    br(S, 5'd1, 16'h5A5A, "R5 data 9/2");
    flush();

    // R7 command while busy
    bw(S, 5'd1, 16'h1111);
    bw(S, 5'd0, mk(5'b00101, 5'd20, 5'd4));
    bw(S, 5'd0, mk(5'b00101, 5'd31, 5'd31));
    br(S, 5'd0, mk(5'b00101, 5'd20, 5'd4), "R7 fields kept busy");
    br(S, 5'd0, {1'b0, mk(5'b00101, 5'd20, 5'd4)}[15:0] & 16'h7FFF, "R7 fields kept idle");
    run_cmd(mk(5'b00110, 5'd31, 5'd31), "R7 rd 31/31");
    br(S, 5'd1, 16'hB1B1, "R7 bank31 unchanged");
    run_cmd(mk(5'b00110, 5'd20, 5'd4), "R7 rd 20/4");
    br(S, 5'd1, 16'h1111, "R7 first cmd done");
    flush();

    // R8 unknown opcode
    bw(S, 5'd1, 16'h7777);
    run_cmd(mk(5'b11111, 5'd7, 5'd13), "R8 bad op");
    run_cmd(mk(5'b00110, 5'd7, 5'd13), "R8 rd 7/13");
    br(S, 5'd1, 16'hC2C2, "R8 bank unchanged");
    flush();

    // R10 start bit clear
    bw(S, 5'd0, 16'h1800 | (16'd2 << 5) | 16'd3);
    br(S, 5'd0, mk(5'b00110, 5'd7, 5'd13) & 16'h7FFF, "R10 cmd unchanged");
    br(S, 5'd1, 16'hC2C2, "R10 data unchanged");
    flush();

    // R5 values seen through flat mode
    strap_addr = 5'd0;
    @(negedge clk);
    br(5'd9,  5'd2,  16'h5A5A, "R5 flat 9/2");
    br(5'd20, 5'd4,  16'h1111, "R5 flat 20/4");
    br(5'd31, 5'd31, 16'hB1B1, "R5 flat 31/31");
    flush();

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: pending responses got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule